// File: doc/BRIEF.md
# Error Event Flag Controller

This block gathers one-cycle event pulses from a memory-checking engine (a test-complete event and five error events) and holds them in sticky flags. Two flag sets are kept side by side. The interrupt set records every event and drives a maskable processor interrupt. The non-maskable set records only the error events, and only while a 4-bit arming key holds its enabling value. Software clears or sets flags through write-one registers and changes configuration through a single write port. Any configurable register can be locked against writes, and a lock can be made permanent until reset.

Event bit positions on `evt_i` and on both flag sets are: 0 test complete, 1 CRC mismatch, 2 uncorrectable error, 3 correctable error, 4 watchdog underflow, 5 watchdog overflow. The non-maskable set leaves out bit 0, so its bit k holds event k+1.

Top module: `evflag_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, all flags, the global bit, `int_pulse_o`, `nmi_o`, the enable mask, the lock bits and the commit bits are 0, and the arming key reads 0xA.
- R2: A pulse on `evt_i[k]` sets interrupt flag k (bit k of `int_flags_o`) at the next clock edge, whatever the enable mask holds.
- R3: A write to select 1 (interrupt force) sets the interrupt flags whose data bits are 1. A write to select 2 (interrupt clear) clears them. A flag that is set and cleared in the same cycle ends up set. A write to select 0 loads the enable mask.
- R4: The global bit (bit 6 of `int_flags_o`) sets one cycle after an enabled interrupt flag is seen while the global bit is clear. `int_pulse_o` is high for exactly that one cycle. Flags whose enable bit is 0 never set the global bit.
- R5: Data bit 6 of an interrupt clear write clears the global bit. If enabled flags are still set, the global bit sets again and pulses one cycle later.
- R6: An error event `evt_i[k]` (k = 1..5) sets non-maskable flag k-1 only while the key (written with select 3) equals 0x5. The value 0xA and every other value block this. The test-complete event never reaches the non-maskable set.
- R7: A write to select 4 sets, and a write to select 5 clears, the non-maskable flags whose data bits are 1. Forcing works whatever the key holds. `nmi_o` is high whenever any non-maskable flag is set.
- R8: A write to select 6 loads the lock bits: bit 0 guards the enable mask, bit 1 the key, bit 2 the interrupt force register, bit 3 the non-maskable force register. A write to a guarded register is ignored while its bit is 1, and takes effect again once the bit is cleared.
- R9: A write to select 7 ORs its data into the commit bits. A committed bit also sets the matching lock bit, and that lock bit then stays set. Only reset clears commit bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 6 | Event pulses from the checking engine |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 7 | Write data |
| int_flags_o | output | 7 | Interrupt flags, bit 6 is the global bit |
| int_pulse_o | output | 1 | One-cycle processor interrupt request |
| nmi_flags_o | output | 5 | Non-maskable flags for the error events |
| nmi_o | output | 1 | Non-maskable interrupt request level |
| int_en_o | output | 6 | Current interrupt enable mask |
| nmi_key_o | output | 4 | Current arming key |
| lock_o | output | 4 | Current lock bits |
| commit_o | output | 4 | Current commit bits |

## Verification
The bench drives the test-complete event alone and then the error events together, first with the mask and the key closed and then with them open. This separates latching (the flags always record events) from gating (the global bit and the non-maskable set). The key is tried at its enabling value, at its blocking value and at an unrelated value, so that a decoder accepting anything but 0xA is caught. Clearing and setting the same flag in one cycle exposes the set-over-clear priority. Clearing only the global bit while an enabled flag remains shows the re-arm pulse, as opposed to clearing both. The lock, unlock, commit and reset sequence shows which protection software can undo and which only reset can undo.

// File: rtl/evflag_pkg.sv
package evflag_pkg;

   localparam int SEL_W    = 3;
   localparam int NUM_LOCK = 4;

   typedef enum logic [SEL_W-1:0] {
      SEL_INT_EN  = 3'd0,
      SEL_INT_FRC = 3'd1,
      SEL_INT_CLR = 3'd2,
      SEL_NMI_KEY = 3'd3,
      SEL_NMI_FRC = 3'd4,
      SEL_NMI_CLR = 3'd5,
      SEL_LOCK    = 3'd6,
      SEL_COMMIT  = 3'd7
   } reg_sel_e;

   // lock / commit bit positions of the guarded registers
   localparam int LK_INT_EN  = 0;
   localparam int LK_NMI_KEY = 1;
   localparam int LK_INT_FRC = 2;
   localparam int LK_NMI_FRC = 3;

endpackage

// File: rtl/evflag_cell.sv
module evflag_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb flag_d = set_i | (flag_o & ~clr_i);
      end else begin : g_clr_first
         always_comb flag_d = (set_i | flag_o) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= flag_d;
   end
endmodule

// File: rtl/evflag_protect.sv
module evflag_protect #(
   parameter int NUM_LOCK = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lock_wr_i,
   input  logic                commit_wr_i,
   input  logic [NUM_LOCK-1:0] data_i,
   output logic [NUM_LOCK-1:0] lock_o,
   output logic [NUM_LOCK-1:0] commit_o
);
   logic [NUM_LOCK-1:0] commit_d;
   logic [NUM_LOCK-1:0] lock_d;

   always_comb begin
      commit_d = commit_o | (commit_wr_i ? data_i : '0);
      lock_d   = (lock_wr_i ? data_i : lock_o) | commit_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_o <= '0;
         lock_o   <= '0;
      end else begin
         commit_o <= commit_d;
         lock_o   <= lock_d;
      end
   end
endmodule

// File: rtl/evflag_global.sv
module evflag_global #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags_i,
   input  logic [N-1:0] en_i,
   input  logic         clr_i,
   output logic         glob_o,
   output logic         pulse_o
);
   logic arm;

   always_comb arm = ~glob_o & (|(flags_i & en_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_o  <= 1'b0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= arm;
         if (arm)        glob_o <= 1'b1;
         else if (clr_i) glob_o <= 1'b0;
      end
   end
endmodule

// File: rtl/evflag_ctrl.sv
module evflag_ctrl
   import evflag_pkg::*;
#(
   parameter int              NUM_EVT  = 6,
   parameter int              KEY_W    = 4,
   parameter logic [KEY_W-1:0] KEY_ON  = 4'h5,
   parameter logic [KEY_W-1:0] KEY_OFF = 4'hA,
   parameter int              DATA_W   = NUM_EVT + 1,
   parameter bit              SET_WINS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_EVT-1:0]  evt_i,
   input  logic                wr_en_i,
   input  logic [SEL_W-1:0]    wr_sel_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   output logic [NUM_EVT:0]    int_flags_o,
   output logic                int_pulse_o,
   output logic [NUM_EVT-2:0]  nmi_flags_o,
   output logic                nmi_o,
   output logic [NUM_EVT-1:0]  int_en_o,
   output logic [KEY_W-1:0]    nmi_key_o,
   output logic [NUM_LOCK-1:0] lock_o,
   output logic [NUM_LOCK-1:0] commit_o
);
   localparam int NUM_ERR  = NUM_EVT - 1;
   localparam int GLOB_BIT = NUM_EVT;

   generate
      if (NUM_EVT < 2) begin : g_bad_evt
         $error("NUM_EVT must be at least 2");
      end
      if (DATA_W < NUM_EVT + 1 || DATA_W < KEY_W || DATA_W < NUM_LOCK) begin : g_bad_data
         $error("DATA_W too narrow for the register fields");
      end
      if (KEY_ON == KEY_OFF) begin : g_bad_key
         $error("KEY_ON and KEY_OFF must differ");
      end
   endgenerate

   // write decode
   logic hit_en, hit_ifrc, hit_iclr, hit_key, hit_nfrc, hit_nclr, hit_lock, hit_commit;
   always_comb begin
      hit_en     = wr_en_i && (wr_sel_i == SEL_INT_EN);
      hit_ifrc   = wr_en_i && (wr_sel_i == SEL_INT_FRC);
      hit_iclr   = wr_en_i && (wr_sel_i == SEL_INT_CLR);
      hit_key    = wr_en_i && (wr_sel_i == SEL_NMI_KEY);
      hit_nfrc   = wr_en_i && (wr_sel_i == SEL_NMI_FRC);
      hit_nclr   = wr_en_i && (wr_sel_i == SEL_NMI_CLR);
      hit_lock   = wr_en_i && (wr_sel_i == SEL_LOCK);
      hit_commit = wr_en_i && (wr_sel_i == SEL_COMMIT);
   end

   // protection bits
   logic [NUM_LOCK-1:0] lock_q, commit_q;
   evflag_protect #(.NUM_LOCK(NUM_LOCK)) u_prot (
      .clk         (clk),
      .rst_n       (rst_n),
      .lock_wr_i   (hit_lock),
      .commit_wr_i (hit_commit),
      .data_i      (wr_data_i[NUM_LOCK-1:0]),
      .lock_o      (lock_q),
      .commit_o    (commit_q)
   );

   // guarded configuration registers
   logic [NUM_EVT-1:0] en_q;
   logic [KEY_W-1:0]   key_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         key_q <= KEY_OFF;
      end else begin
         if (hit_en && !lock_q[LK_INT_EN])   en_q  <= wr_data_i[NUM_EVT-1:0];
         if (hit_key && !lock_q[LK_NMI_KEY]) key_q <= wr_data_i[KEY_W-1:0];
      end
   end

   // flag set / clear vectors
   logic               nmi_arm;
   logic [NUM_EVT-1:0] int_set, int_clr, int_flag;
   logic [NUM_ERR-1:0] nmi_set, nmi_clr, nmi_flag;
   always_comb begin
      nmi_arm = (key_q == KEY_ON);
      int_set = evt_i
              | ({NUM_EVT{hit_ifrc & ~lock_q[LK_INT_FRC]}} & wr_data_i[NUM_EVT-1:0]);
      int_clr = {NUM_EVT{hit_iclr}} & wr_data_i[NUM_EVT-1:0];
      nmi_set = ({NUM_ERR{nmi_arm}} & evt_i[NUM_EVT-1:1])
              | ({NUM_ERR{hit_nfrc & ~lock_q[LK_NMI_FRC]}} & wr_data_i[NUM_ERR-1:0]);
      nmi_clr = {NUM_ERR{hit_nclr}} & wr_data_i[NUM_ERR-1:0];
   end

   generate
      for (genvar g = 0; g < NUM_EVT; g++) begin : g_int
         evflag_cell #(.SET_WINS(SET_WINS)) u_cell (
            .clk (clk), .rst_n (rst_n),
            .set_i (int_set[g]), .clr_i (int_clr[g]), .flag_o (int_flag[g])
         );
      end
      for (genvar g = 0; g < NUM_ERR; g++) begin : g_nmi
         evflag_cell #(.SET_WINS(SET_WINS)) u_cell (
            .clk (clk), .rst_n (rst_n),
            .set_i (nmi_set[g]), .clr_i (nmi_clr[g]), .flag_o (nmi_flag[g])
         );
      end
   endgenerate

   logic glob_q;
   evflag_global #(.N(NUM_EVT)) u_glob (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (int_flag),
      .en_i    (en_q),
      .clr_i   (hit_iclr & wr_data_i[GLOB_BIT]),
      .glob_o  (glob_q),
      .pulse_o (int_pulse_o)
   );

   always_comb begin
      int_flags_o = {glob_q, int_flag};
      nmi_flags_o = nmi_flag;
      nmi_o       = |nmi_flag;
      int_en_o    = en_q;
      nmi_key_o   = key_q;
      lock_o      = lock_q;
      commit_o    = commit_q;
   end
endmodule

// File: rtl/evflag_chk.sv
module evflag_chk
   import evflag_pkg::*;
#(
   parameter int               NUM_EVT = 6,
   parameter int               KEY_W   = 4,
   parameter logic [KEY_W-1:0] KEY_ON  = 4'h5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en_i,
   input logic [SEL_W-1:0]    wr_sel_i,
   input logic [NUM_EVT:0]    int_flags_o,
   input logic                int_pulse_o,
   input logic [NUM_EVT-2:0]  nmi_flags_o,
   input logic [NUM_EVT-1:0]  int_en_o,
   input logic [KEY_W-1:0]    nmi_key_o,
   input logic [NUM_LOCK-1:0] lock_o,
   input logic [NUM_LOCK-1:0] commit_o
);
   // R4
   glob_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_flags_o[NUM_EVT] && ((int_flags_o[NUM_EVT-1:0] & int_en_o) != '0))
      |=> (int_flags_o[NUM_EVT] && int_pulse_o));

   // R4
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_pulse_o |=> !int_pulse_o);

   // R4
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_flags_o[NUM_EVT] && ((int_flags_o[NUM_EVT-1:0] & int_en_o) == '0))
      |=> !int_pulse_o);

   // R6
   nmi_key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((nmi_key_o != KEY_ON) && !(wr_en_i && wr_sel_i == SEL_NMI_FRC))
      |=> ((nmi_flags_o & ~$past(nmi_flags_o)) == '0));

   // R8
   en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o[LK_INT_EN] && wr_en_i && wr_sel_i == SEL_INT_EN) |=> $stable(int_en_o));

   // R9
   commit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_o != '0) |=> ((commit_o & $past(commit_o)) == $past(commit_o)));

   // R9
   commit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lock_o & commit_o) == commit_o));
endmodule

bind evflag_ctrl evflag_chk #(
   .NUM_EVT (NUM_EVT),
   .KEY_W   (KEY_W),
   .KEY_ON  (KEY_ON)
) u_evflag_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en_i     (wr_en_i),
   .wr_sel_i    (wr_sel_i),
   .int_flags_o (int_flags_o),
   .int_pulse_o (int_pulse_o),
   .nmi_flags_o (nmi_flags_o),
   .int_en_o    (int_en_o),
   .nmi_key_o   (nmi_key_o),
   .lock_o      (lock_o),
   .commit_o    (commit_o)
);

// File: tb/tb_evflag_ctrl.sv
`timescale 1ns/1ps
module tb_evflag_ctrl;
   localparam int S_EN = 0, S_IFRC = 1, S_ICLR = 2, S_KEY = 3,
                  S_NFRC = 4, S_NCLR = 5, S_LOCK = 6, S_COMMIT = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] evt = '0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = '0;
   logic [6:0] wr_data = '0;
   logic [6:0] int_flags;
   logic       int_pulse;
   logic [4:0] nmi_flags;
   logic       nmi;
   logic [5:0] int_en;
   logic [3:0] nmi_key;
   logic [3:0] lock, commit;

   evflag_ctrl dut (
      .clk (clk), .rst_n (rst_n), .evt_i (evt),
      .wr_en_i (wr_en), .wr_sel_i (wr_sel), .wr_data_i (wr_data),
      .int_flags_o (int_flags), .int_pulse_o (int_pulse),
      .nmi_flags_o (nmi_flags), .nmi_o (nmi),
      .int_en_o (int_en), .nmi_key_o (nmi_key),
      .lock_o (lock), .commit_o (commit)
   );

   always #2.5 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   // behavioural reference model
   logic [5:0] mf = '0, of;
   logic       mg = 1'b0, og, mp = 1'b0;
   logic [4:0] mn = '0, on;
   logic [5:0] me = '0, oe;
   logic [3:0] mk = 4'hA, ok, ml = '0, ol, mc = '0, oc;
   logic       s, c;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mf = '0; mg = 1'b0; mp = 1'b0; mn = '0; me = '0;
         mk = 4'hA; ml = '0; mc = '0;
      end else begin
         of = mf; og = mg; on = mn; oe = me; ok = mk; ol = ml; oc = mc;
         for (int i = 0; i < 6; i++) begin
            s = evt[i] || (wr_en && wr_sel == S_IFRC && !ol[2] && wr_data[i]);
            c = wr_en && wr_sel == S_ICLR && wr_data[i];
            mf[i] = s ? 1'b1 : (c ? 1'b0 : of[i]);
         end
         if (!og && ((of & oe) != 0)) begin
            mg = 1'b1; mp = 1'b1;
         end else begin
            mp = 1'b0;
            if (wr_en && wr_sel == S_ICLR && wr_data[6]) mg = 1'b0;
         end
         for (int i = 0; i < 5; i++) begin
            s = (evt[i+1] && ok == 4'h5) || (wr_en && wr_sel == S_NFRC && !ol[3] && wr_data[i]);
            c = wr_en && wr_sel == S_NCLR && wr_data[i];
            mn[i] = s ? 1'b1 : (c ? 1'b0 : on[i]);
         end
         if (wr_en && wr_sel == S_EN  && !ol[0]) me = wr_data[5:0];
         if (wr_en && wr_sel == S_KEY && !ol[1]) mk = wr_data[3:0];
         if (wr_en && wr_sel == S_COMMIT) mc = oc | wr_data[3:0];
         if (wr_en && wr_sel == S_LOCK) ml = wr_data[3:0];
         ml = ml | mc;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         check("R2/R3 int flags",       {26'd0, int_flags[5:0]}, {26'd0, mf});
         check("R4/R5 global bit",      {31'd0, int_flags[6]},   {31'd0, mg});
         check("R4/R5 int pulse",       {31'd0, int_pulse},      {31'd0, mp});
         check("R6/R7 nmi flags",       {27'd0, nmi_flags},      {27'd0, mn});
         check("R7 nmi level",          {31'd0, nmi},            {31'd0, |mn});
         check("R3/R8 enable mask",     {26'd0, int_en},         {26'd0, me});
         check("R6/R8 key",             {28'd0, nmi_key},        {28'd0, mk});
         check("R8/R9 lock",            {28'd0, lock},           {28'd0, ml});
         check("R9 commit",             {28'd0, commit},         {28'd0, mc});
      end
   end

   task automatic wr(input int sel, input logic [6:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic ev(input logic [5:0] m);
      @(posedge clk); #1; evt = m;
      @(posedge clk); #1; evt = '0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   int wd_cnt = 0;
   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 20000 && !done_flag) begin
         done_flag = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=<20000", wd_cnt);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   logic [6:0] snap;

   initial begin
      repeat (3) @(posedge clk);
      settle();
      // R1 reset state
      check("R1 flags in reset", {25'd0, int_flags}, 0);
      check("R1 key in reset",   {28'd0, nmi_key},   32'hA);
      #1 rst_n = 1'b1;
      settle();
      check("R1 flags after reset", {25'd0, int_flags}, 0);
      check("R1 lock after reset",  {28'd0, lock},      0);
      check("R1 nmi after reset",   {31'd0, nmi},       0);

      // R2: event latches with mask closed, no global
      ev(6'h01); settle();
      check("R2 done event latched", {25'd0, int_flags}, 32'h01);
      repeat (2) settle();
      check("R4 masked flag no global", {31'd0, int_flags[6]}, 0);

      // R4: open mask, global sets and pulses once
      wr(S_EN, 7'h01); settle();
      check("R4 global not yet", {31'd0, int_flags[6]}, 0);
      settle();
      check("R4 global set", {31'd0, int_flags[6]}, 1);
      check("R4 pulse high", {31'd0, int_pulse},    1);
      settle();
      check("R4 pulse single", {31'd0, int_pulse},  0);

      // R5: clear only global, re-arm
      wr(S_ICLR, 7'h40); settle();
      check("R5 global cleared", {31'd0, int_flags[6]}, 0);
      settle();
      check("R5 global re-armed", {31'd0, int_flags[6]}, 1);
      check("R5 re-arm pulse",    {31'd0, int_pulse},    1);
      wr(S_ICLR, 7'h41); repeat (2) settle();
      check("R5 full clear", {25'd0, int_flags}, 0);
      check("R5 no pulse after full clear", {31'd0, int_pulse}, 0);

      // R3: force, clear, set-over-clear
      wr(S_IFRC, 7'h2A); settle();
      check("R3 force", {25'd0, int_flags}, 32'h2A);
      @(posedge clk); #1;
      evt = 6'h02; wr_en = 1'b1; wr_sel = 3'(S_ICLR); wr_data = 7'h0A;
      @(posedge clk); #1;
      evt = '0; wr_en = 1'b0; wr_data = '0;
      settle();
      check("R3 set wins over clear", {25'd0, int_flags}, 32'h22);
      wr(S_ICLR, 7'h22); settle();
      check("R3 clear", {25'd0, int_flags}, 0);

      // R6: key gating
      ev(6'h3E); settle();
      check("R6 key 0xA blocks", {27'd0, nmi_flags}, 0);
      check("R2 error events latched", {26'd0, int_flags[5:0]}, 32'h3E);
      wr(S_ICLR, 7'h3E);
      wr(S_KEY, 7'h03); ev(6'h3E); settle();
      check("R6 key 0x3 blocks", {27'd0, nmi_flags}, 0);
      wr(S_ICLR, 7'h3E);
      wr(S_KEY, 7'h05); ev(6'h01); settle();
      check("R6 done never reaches nmi", {27'd0, nmi_flags}, 0);
      ev(6'h0A); settle();
      check("R6 armed errors latch", {27'd0, nmi_flags}, 32'h05);
      check("R7 nmi level high", {31'd0, nmi}, 1);

      // R7: nmi clear and force
      wr(S_NCLR, 7'h05); settle();
      check("R7 nmi clear", {27'd0, nmi_flags}, 0);
      check("R7 nmi level low", {31'd0, nmi}, 0);
      wr(S_KEY, 7'h0A);
      wr(S_NFRC, 7'h10); settle();
      check("R7 force with key off", {27'd0, nmi_flags}, 32'h10);
      wr(S_NCLR, 7'h1F);
      wr(S_ICLR, 7'h7F);

      // R8: lock and unlock
      wr(S_LOCK, 7'h01);
      wr(S_EN, 7'h3F); settle();
      check("R8 locked enable ignored", {26'd0, int_en}, 32'h01);
      wr(S_LOCK, 7'h0F);
      wr(S_KEY, 7'h05); settle();
      check("R8 locked key ignored", {28'd0, nmi_key}, 32'hA);
      wr(S_IFRC, 7'h3F); settle();
      check("R8 locked int force ignored", {26'd0, int_flags[5:0]}, 0);
      wr(S_NFRC, 7'h1F); settle();
      check("R8 locked nmi force ignored", {27'd0, nmi_flags}, 0);
      wr(S_LOCK, 7'h00);
      wr(S_EN, 7'h3F); settle();
      check("R8 unlock restores writes", {26'd0, int_en}, 32'h3F);

      // R9: commit
      wr(S_COMMIT, 7'h04); settle();
      check("R9 commit set",       {28'd0, commit}, 32'h4);
      check("R9 commit sets lock", {28'd0, lock},   32'h4);
      wr(S_LOCK, 7'h00); settle();
      check("R9 lock stays", {28'd0, lock}, 32'h4);
      snap = int_flags;
      wr(S_IFRC, 7'h3F); settle();
      check("R9 committed force ignored", {26'd0, int_flags[5:0]}, {26'd0, snap[5:0]});
      wr(S_COMMIT, 7'h01); settle();
      check("R9 commit accumulates", {28'd0, commit}, 32'h5);
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();
      check("R9 reset clears commit", {28'd0, commit}, 0);
      check("R1 reset clears lock",   {28'd0, lock},   0);
      check("R1 reset restores key",  {28'd0, nmi_key}, 32'hA);

      repeat (2) settle();
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule